// File: doc/BRIEF.md
# Flash Write-Status Polling Controller

This block is the host-side engine that decides when a parallel flash device has finished an embedded program or erase operation. The command sequencer starts it with a one-cycle pulse and gives it the operation kind, the data word that was programmed and an address inside the block being worked on. It waits until the sequencer reports that the last command write has completed. It then issues status reads through a simple request/acknowledge read port until the device shows that the operation is over.

Two detection methods are available, chosen by one input and latched at start. In data-poll mode the controller watches status bit 7. In a program operation the operation is over when that bit equals bit 7 of the programmed word. In an erase operation the operation is over when that bit reads 1. In toggle mode the controller compares status bit 6 between consecutive reads: the operation is still running while that bit keeps changing and is over when two consecutive reads agree. When completion is seen, bit 7 may have settled before the lower bits. For that reason the controller always issues one more read and returns that word as the result. In a program operation, a result that differs from the programmed word is an error. A programmable limit on status reads ends a run that never completes and flags it as an error.

Top module: `flash_poll_ctrl`

## Requirements
- R1: Under synchronous reset, `done`, `error`, `busy` and `rd_req` are low and `result` is zero.
- R2: A `start` accepted while idle latches the configuration and raises `busy`. No read is requested until `cmd_wr_done` has been sampled high, starting in the cycle after `start`. Every read is then issued at the `poll_addr` latched at start.
- R3: `rd_req` stays high with a stable `rd_addr` until `rd_ack` is sampled. Each acknowledged cycle counts as exactly one completed read.
- R4: When `use_toggle`=0 and `op_erase`=0, a status read is complete when its bit 7 equals bit 7 of `exp_data`.
- R5: When `use_toggle`=0 and `op_erase`=1, a status read is complete when its bit 7 is 1.
- R6: When `use_toggle`=1, a status read is complete when its bit 6 equals bit 6 of the previous status read of the same run. The first status read of a run is never complete.
- R7: After a complete status read, exactly one more read is issued. Its full word becomes `result`, and `done` then pulses for one cycle with `busy` low.
- R8: When `op_erase`=0, a confirming word that differs from `exp_data` gives `done` with `error` high. When `op_erase`=1 the confirming word is not compared.
- R9: If `max_polls` status reads all come back incomplete, `done` pulses with `error` high, no confirming read is issued, and `result` keeps its previous value. A limit of 0 acts as 1.
- R10: A `start` that arrives while `busy` is high is ignored, and the running operation finishes exactly as configured.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin polling |
| op_erase | input | 1 | 1 = erase operation, 0 = program operation |
| use_toggle | input | 1 | 1 = bit-6 toggle detection, 0 = bit-7 data polling |
| exp_data | input | DW | Word that was programmed |
| poll_addr | input | AW | Read address inside the target block |
| max_polls | input | CW | Maximum number of status reads |
| cmd_wr_done | input | 1 | Final command write cycle has finished |
| rd_req | output | 1 | Read request, held until acknowledged |
| rd_addr | output | AW | Read address |
| rd_ack | input | 1 | Read completed, `rd_data` valid |
| rd_data | input | DW | Word returned by the read |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle end-of-operation pulse |
| error | output | 1 | Failure flag, valid with `done`, held until next start |
| result | output | DW | Word from the confirming read |

## Verification
A wrong internal state shows at the ports within one read round trip. A detector that declares completion too early, or never, changes the number of read acknowledges the bench counts, and it also makes `result` differ from the final word. That happens because the device model returns wrong low bits on the first settled read and the correct word only on the next one. A stale toggle history or budget counter shifts `done` by at least one read, and the bench's per-clock comparison of `busy` catches that in the same cycle. A lost configuration latch after a second `start` shows up as a changed `result` or `error` at the `done` pulse of that run.

// File: rtl/flash_poll_pkg.sv
package flash_poll_pkg;

    // Status bit positions that the device drives during an embedded operation
    localparam int STAT_BIT = 7;
    localparam int TOG_BIT  = 6;

    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_WAIT_CMD = 2'd1,
        ST_STATUS   = 2'd2,
        ST_CONFIRM  = 2'd3
    } poll_state_e;

    typedef enum logic {
        OP_PROGRAM = 1'b0,
        OP_ERASE   = 1'b1
    } op_kind_e;

    typedef enum logic {
        DET_DATA   = 1'b0,
        DET_TOGGLE = 1'b1
    } det_kind_e;

    typedef struct packed {
        op_kind_e  op;
        det_kind_e det;
    } job_cfg_t;

    // Bit-7 completion rule for data polling
    function automatic logic stat_settled(op_kind_e op, logic rd7, logic exp7);
        return (op == OP_ERASE) ? rd7 : (rd7 == exp7);
    endfunction

endpackage

// File: rtl/flash_poll_detect.sv
module flash_poll_detect
    import flash_poll_pkg::*;
(
    input  job_cfg_t cfg,
    input  logic     rd_stat,
    input  logic     rd_tog,
    input  logic     exp_stat,
    input  logic     prev_tog,
    input  logic     have_prev,
    output logic     complete
);
    logic data_hit;
    logic tog_hit;

    always_comb begin
        data_hit = stat_settled(cfg.op, rd_stat, exp_stat);
        tog_hit  = have_prev && (rd_tog == prev_tog);
        complete = (cfg.det == DET_TOGGLE) ? tog_hit : data_hit;
    end
endmodule

// File: rtl/flash_poll_budget.sv
module flash_poll_budget #(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          step,
    input  logic [CW-1:0] limit,
    output logic          last
);
    logic [CW-1:0] used_q;
    logic [CW:0]   next_used;

    assign next_used = {1'b0, used_q} + {{CW{1'b0}}, 1'b1};
    // A zero limit behaves as a limit of one
    assign last      = next_used >= {1'b0, limit};

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            used_q <= '0;
        end else if (step) begin
            used_q <= next_used[CW-1:0];
        end
    end
endmodule

// File: rtl/flash_poll_ctrl.sv
module flash_poll_ctrl
    import flash_poll_pkg::*;
#(
    parameter int DW = 8,
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start,
    input  logic          op_erase,
    input  logic          use_toggle,
    input  logic [DW-1:0] exp_data,
    input  logic [AW-1:0] poll_addr,
    input  logic [CW-1:0] max_polls,
    input  logic          cmd_wr_done,
    output logic          rd_req,
    output logic [AW-1:0] rd_addr,
    input  logic          rd_ack,
    input  logic [DW-1:0] rd_data,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [DW-1:0] result
);
    poll_state_e   state_q;
    job_cfg_t      cfg_q;
    logic [DW-1:0] exp_q;
    logic [AW-1:0] addr_q;
    logic [CW-1:0] max_q;
    logic          prev_tog_q;
    logic          have_prev_q;
    logic          complete;
    logic          budget_last;
    logic          accept;
    logic          status_step;

    assign accept      = (state_q == ST_IDLE) && start;
    assign status_step = (state_q == ST_STATUS) && rd_ack;

    flash_poll_detect u_detect (
        .cfg       (cfg_q),
        .rd_stat   (rd_data[STAT_BIT]),
        .rd_tog    (rd_data[TOG_BIT]),
        .exp_stat  (exp_q[STAT_BIT]),
        .prev_tog  (prev_tog_q),
        .have_prev (have_prev_q),
        .complete  (complete)
    );

    flash_poll_budget #(.CW(CW)) u_budget (
        .clk   (clk),
        .rst   (rst),
        .clr   (accept),
        .step  (status_step),
        .limit (max_q),
        .last  (budget_last)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q     <= ST_IDLE;
            cfg_q       <= '{op: OP_PROGRAM, det: DET_DATA};
            exp_q       <= '0;
            addr_q      <= '0;
            max_q       <= '0;
            prev_tog_q  <= 1'b0;
            have_prev_q <= 1'b0;
            done        <= 1'b0;
            error       <= 1'b0;
            result      <= '0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        cfg_q.op    <= op_kind_e'(op_erase);
                        cfg_q.det   <= det_kind_e'(use_toggle);
                        exp_q       <= exp_data;
                        addr_q      <= poll_addr;
                        max_q       <= max_polls;
                        have_prev_q <= 1'b0;
                        error       <= 1'b0;
                        state_q     <= ST_WAIT_CMD;
                    end
                end
                ST_WAIT_CMD: begin
                    if (cmd_wr_done) begin
                        state_q <= ST_STATUS;
                    end
                end
                ST_STATUS: begin
                    if (rd_ack) begin
                        prev_tog_q  <= rd_data[TOG_BIT];
                        have_prev_q <= 1'b1;
                        if (complete) begin
                            state_q <= ST_CONFIRM;
                        end else if (budget_last) begin
                            error   <= 1'b1;
                            done    <= 1'b1;
                            state_q <= ST_IDLE;
                        end
                    end
                end
                ST_CONFIRM: begin
                    if (rd_ack) begin
                        result  <= rd_data;
                        error   <= (cfg_q.op == OP_PROGRAM) && (rd_data != exp_q);
                        done    <= 1'b1;
                        state_q <= ST_IDLE;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign busy    = (state_q != ST_IDLE);
    assign rd_req  = (state_q == ST_STATUS) || (state_q == ST_CONFIRM);
    assign rd_addr = addr_q;

endmodule

// File: rtl/flash_poll_chk.sv
module flash_poll_chk #(
    parameter int DW = 8,
    parameter int AW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          op_erase,
    input logic [DW-1:0] exp_data,
    input logic [AW-1:0] poll_addr,
    input logic          cmd_wr_done,
    input logic          rd_req,
    input logic [AW-1:0] rd_addr,
    input logic          rd_ack,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [DW-1:0] result
);
    logic          seen_cmd_q;
    logic          op_q;
    logic [DW-1:0] exp_q;
    logic [AW-1:0] addr_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            seen_cmd_q <= 1'b0;
            op_q       <= 1'b0;
            exp_q      <= '0;
            addr_q     <= '0;
        end else begin
            seen_cmd_q <= busy && (seen_cmd_q || cmd_wr_done);
            if (start && !busy) begin
                op_q   <= op_erase;
                exp_q  <= exp_data;
                addr_q <= poll_addr;
            end
        end
    end

    assert_reset_quiet_R1: assert property (@(posedge clk)
        rst |=> (!done && !busy && !rd_req && !error && result == '0));

    assert_no_early_read_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> seen_cmd_q);

    assert_read_addr_R2: assert property (@(posedge clk) disable iff (rst)
        rd_req |-> (rd_addr == addr_q));

    assert_req_held_R3: assert property (@(posedge clk) disable iff (rst)
        (rd_req && !rd_ack) |=> (rd_req && $stable(rd_addr)));

    assert_done_pulse_R7: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_idle_R7: assert property (@(posedge clk) disable iff (rst)
        done |-> (!busy && !rd_req));

    assert_program_match_R8: assert property (@(posedge clk) disable iff (rst)
        (done && !error && !op_q) |-> (result == exp_q));

    assert_error_with_done_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(error) |-> done);

endmodule

bind flash_poll_ctrl flash_poll_chk #(.DW(DW), .AW(AW)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .start       (start),
    .op_erase    (op_erase),
    .exp_data    (exp_data),
    .poll_addr   (poll_addr),
    .cmd_wr_done (cmd_wr_done),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_ack      (rd_ack),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .result      (result)
);

// File: tb/flash_poll_ctrl_bench.sv
`timescale 1ns/1ps
module flash_poll_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic        op_erase = 1'b0;
    logic        use_toggle = 1'b0;
    logic [7:0]  exp_data = '0;
    logic [15:0] poll_addr = '0;
    logic [15:0] max_polls = '0;
    logic        cmd_wr_done = 1'b0;
    logic        rd_req;
    logic [15:0] rd_addr;
    logic        rd_ack = 1'b0;
    logic [7:0]  rd_data = '0;
    logic        busy, done, error;
    logic [7:0]  result;

    int compared = 0;
    int mismatched = 0;
    bit finished = 0;

    // device model state
    int       dev_busy_reads = 0;
    bit       dev_erase = 0;
    logic [7:0] dev_final = '0;
    int       read_idx = 0;
    int       ack_delay = 0;
    int       wait_cnt = 0;
    logic [7:0] last_res = '0;

    always #2.5 clk = ~clk;

    flash_poll_ctrl u_flash_poll_ctrl (
        .clk(clk), .rst(rst), .start(start), .op_erase(op_erase),
        .use_toggle(use_toggle), .exp_data(exp_data), .poll_addr(poll_addr),
        .max_polls(max_polls), .cmd_wr_done(cmd_wr_done), .rd_req(rd_req),
        .rd_addr(rd_addr), .rd_ack(rd_ack), .rd_data(rd_data), .busy(busy),
        .done(done), .error(error), .result(result)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    // Word the device returns on read number k of a run
    function automatic logic [7:0] dev_word(input int k, input int n,
                                            input bit erase, input logic [7:0] fin);
        logic [7:0] w;
        logic [5:0] kb;
        kb = 6'(k);
        if (k < n)
            w = {(erase ? 1'b0 : ~fin[7]), kb[0], 6'h2A ^ kb};
        else if (k == n)
            w = {(erase ? 1'b1 : fin[7]), fin[6], ~fin[5:0]};
        else
            w = fin;
        return w;
    endfunction

    // read responder
    initial begin
        forever begin
            @(negedge clk);
            if (rd_ack) begin
                rd_ack = 1'b0;
            end else if (rd_req) begin
                if (wait_cnt < ack_delay) begin
                    wait_cnt++;
                end else begin
                    rd_data = dev_word(read_idx, dev_busy_reads, dev_erase, dev_final);
                    read_idx++;
                    rd_ack = 1'b1;
                    wait_cnt = 0;
                end
            end
        end
    end

    task automatic predict(input int n, input bit erase, input bit tog,
                           input logic [7:0] fin, input logic [7:0] expd,
                           input int maxp, output bit p_err,
                           output logic [7:0] p_res, output int p_reads);
        int lim;
        int k;
        int cnt;
        bit complete;
        bit havep;
        logic prev;
        logic [7:0] v;
        lim = (maxp == 0) ? 1 : maxp;
        k = 0; cnt = 0; complete = 0; havep = 0; prev = 0;
        while (!complete && cnt < lim) begin
            v = dev_word(k, n, erase, fin);
            k++; cnt++;
            if (tog) begin
                complete = havep && (v[6] == prev);
                prev = v[6];
                havep = 1;
            end else begin
                complete = erase ? v[7] : (v[7] == expd[7]);
            end
        end
        if (complete) begin
            v = dev_word(k, n, erase, fin);
            k++;
            p_res = v;
            p_err = !erase && (v != expd);
        end else begin
            p_res = last_res;
            p_err = 1;
        end
        p_reads = k;
    endtask

    task automatic run_op(input string req, input bit erase, input bit tog,
                          input int n, input logic [7:0] fin, input logic [7:0] expd,
                          input int maxp, input logic [15:0] addr,
                          input int cmd_gap, input int dly, input int restart_at);
        bit p_err;
        logic [7:0] p_res;
        int p_reads;
        int cyc;
        bit got;
        predict(n, erase, tog, fin, expd, maxp, p_err, p_res, p_reads);
        dev_busy_reads = n; dev_erase = erase; dev_final = fin;
        read_idx = 0; ack_delay = dly; wait_cnt = 0;
        @(negedge clk);
        op_erase = erase; use_toggle = tog; exp_data = expd;
        poll_addr = addr; max_polls = 16'(maxp); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        op_erase = ~erase; use_toggle = ~tog; exp_data = ~expd;
        poll_addr = ~addr; max_polls = 16'd1;
        chk(busy == 1'b1, "R2", "busy after start", 32'(busy), 1);
        for (int i = 0; i < cmd_gap; i++) begin
            @(negedge clk);
            chk(rd_req == 1'b0, "R2", "read before command done", 32'(rd_req), 0);
        end
        cmd_wr_done = 1'b1;
        @(negedge clk);
        cmd_wr_done = 1'b0;
        got = 0;
        for (cyc = 0; cyc < 5000; cyc++) begin
            if (cyc == restart_at) start = 1'b1;
            if (cyc == restart_at + 1) start = 1'b0;
            if (done) begin
                got = 1;
                break;
            end
            chk(busy == 1'b1, req, "busy during run", 32'(busy), 1);
            if (rd_req)
                chk(rd_addr == addr, "R2", "read address", 32'(rd_addr), 32'(addr));
            @(negedge clk);
        end
        start = 1'b0;
        if (!got) begin
            chk(0, req, "watchdog: no done", 0, 1);
        end else begin
            chk(busy == 1'b0, "R7", "busy at done", 32'(busy), 0);
            chk(error == p_err, req, "error flag", 32'(error), 32'(p_err));
            chk(result == p_res, req, "result word", 32'(result), 32'(p_res));
            chk(read_idx == p_reads, req, "read count", 32'(read_idx), 32'(p_reads));
            if (!p_err || !(read_idx == p_reads && p_reads <= ((maxp == 0) ? 1 : maxp)))
                last_res = p_res;
            @(negedge clk);
            chk(done == 1'b0, "R7", "done one cycle", 32'(done), 0);
            chk(rd_req == 1'b0, "R7", "no read after done", 32'(rd_req), 0);
        end
        last_res = result;
    endtask

    initial begin
        #(200000 * 5);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        chk(done == 0 && busy == 0 && rd_req == 0 && error == 0, "R1",
            "reset outputs", {done, busy, rd_req, error}, 0);
        chk(result == 8'h00, "R1", "reset result", 32'(result), 0);
        rst = 1'b0;
        @(negedge clk);

        // R4: program, data polling, both bit-7 polarities
        run_op("R4", 0, 0, 5, 8'hA5, 8'hA5, 20, 16'h1234, 3, 0, -1);
        run_op("R4", 0, 0, 0, 8'h3C, 8'h3C, 20, 16'h0040, 0, 2, -1);
        // R5: erase, data polling
        run_op("R5", 1, 0, 4, 8'hFF, 8'hFF, 20, 16'h8000, 2, 1, -1);
        // R8: erase ignores expected word
        run_op("R8", 1, 0, 2, 8'hFF, 8'h00, 20, 16'h8001, 1, 0, -1);
        // R6: toggle detection, program and erase, both bit-6 endings
        run_op("R6", 0, 1, 3, 8'h5A, 8'h5A, 20, 16'h2222, 1, 0, -1);
        run_op("R6", 0, 1, 4, 8'h12, 8'h12, 20, 16'h2224, 1, 3, -1);
        run_op("R6", 1, 1, 6, 8'hFF, 8'hFF, 20, 16'h9000, 0, 1, -1);
        run_op("R6", 0, 1, 0, 8'h77, 8'h77, 20, 16'h2226, 0, 0, -1);
        // R7: confirming read replaces lagging low bits
        run_op("R7", 0, 0, 1, 8'h81, 8'h81, 20, 16'h0100, 0, 0, -1);
        // R8: program mismatch on confirmation
        run_op("R8", 0, 0, 3, 8'h81, 8'h83, 20, 16'h0200, 1, 0, -1);
        // R9: timeouts and boundaries
        run_op("R9", 0, 0, 50, 8'h11, 8'h11, 10, 16'h0300, 0, 0, -1);
        run_op("R9", 0, 0, 9, 8'h22, 8'h22, 10, 16'h0304, 0, 0, -1);
        run_op("R9", 0, 0, 10, 8'h33, 8'h33, 10, 16'h0308, 0, 1, -1);
        run_op("R9", 1, 0, 5, 8'hFF, 8'hFF, 0, 16'h030C, 0, 0, -1);
        run_op("R9", 0, 1, 50, 8'h44, 8'h44, 8, 16'h0310, 0, 0, -1);
        // R10: start during a run is ignored
        run_op("R10", 0, 0, 6, 8'hC3, 8'hC3, 20, 16'h4444, 2, 1, 4);
        run_op("R10", 1, 1, 5, 8'hFF, 8'hFF, 20, 16'h4448, 1, 0, 2);
        // R3: slow acknowledge
        run_op("R3", 0, 0, 2, 8'h69, 8'h69, 20, 16'h5550, 0, 5, -1);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end
endmodule